// File: doc/BRIEF.md
# CRC-16 Record Guard

This block protects records kept in external memory with a 16-bit cyclic check. It takes one byte per cycle and folds each byte into a running 16-bit register in a single step, using closed-form XOR equations rather than eight serial shifts. Bits are taken least significant first. The generator is x^16 + x^15 + x^2 + 1, which in reflected form is 0xA001.

Before a write, the host opens a record in write mode. It streams the record bytes and marks the last one with the end strobe. The block then presents two trailer bytes on consecutive cycles. These bytes are the ones' complement of the register, low byte first, and the host stores them after the record. Before a read, the host opens a record in read mode. It streams the stored record followed by its two trailer bytes, and marks the last byte with the end strobe. The verdict outputs then report whether the final register value equals 0xB001.

A complemented trailer is used so that a reader shorted to ground is rejected. Such a reader returns all zeros for both the data and the check bytes, and the register then ends at 0x0000. A plain, uncomplemented trailer would also end at 0x0000, so it is rejected too.

Top module: `crc16_record_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pass_o`, `fail_o` and `trl_vld_o` are 0.
- R2: Each accepted byte updates the register as eight least-significant-bit-first steps of the reflected generator 0xA001. The register is 0x0000 when a record is opened. From a register value of 0x90F1, the byte 0x75 gives 0x6390.
- R3: `start_i` clears the register to 0x0000, latches `mode_i` (0 means write, 1 means read) and abandons any trailer output in progress. A byte or end strobe presented in the same cycle as `start_i` is discarded.
- R4: In write mode, an accepted end strobe makes `trl_vld_o` high for exactly the two following cycles. `trl_byte_o` carries the inverted low register byte in the first of these cycles and the inverted high register byte in the second.
- R5: A byte presented in the same cycle as the end strobe is folded in before the trailer is formed or the verdict is taken. The result equals that of presenting the byte first and the end strobe alone one cycle later.
- R6: In read mode, an accepted end strobe sets `pass_o`=1 and `fail_o`=0 in the next cycle if the register, including any byte in that cycle, equals 0xB001. Otherwise it sets `pass_o`=0 and `fail_o`=1.
- R7: A read record whose data and trailer are all zero fails. So does a record followed by its plain, uncomplemented register value.
- R8: `pass_o` and `fail_o` change only on a read-mode end strobe. A start or a write-mode end strobe leaves them as they were.
- R9: While the trailer is being output, incoming bytes and end strobes are ignored. The register and both trailer bytes are unaffected.
- R10: `pass_o` and `fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Open a record: clear the register and latch the mode |
| mode_i | input | 1 | 0 = write (generate trailer), 1 = read (check residue) |
| byte_i | input | 8 | Record byte |
| byte_vld_i | input | 1 | `byte_i` is valid this cycle |
| eor_i | input | 1 | End of record; may coincide with the last byte |
| trl_byte_o | output | 8 | Trailer byte, inverted register, low byte first |
| trl_vld_o | output | 1 | `trl_byte_o` is valid |
| pass_o | output | 1 | Last read record ended at the pass residue |
| fail_o | output | 1 | Last read record did not end at the pass residue |

## Verification
Two functions can fall in one cycle: folding the last byte and closing the record. The bench provokes this by raising the end strobe together with the last byte in every record. It judges the result against the same record closed by an end strobe one cycle after its last byte. A byte arriving with `start_i` and bytes and end strobes arriving during trailer output are also provoked. In each case the bench judges the outcome by the trailer bytes and verdict that follow, compared with a bit-serial model.

// File: rtl/crc16_guard_pkg.sv
// Shared constants and types for the CRC-16 record guard.
package crc16_guard_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 2 * BYTE_W;
    localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;
    localparam logic [CRC_W-1:0] PASS_RESIDUE = 16'hB001;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } rec_mode_e;

    typedef enum logic [1:0] {
        EMIT_IDLE = 2'd0,
        EMIT_LOW  = 2'd1,
        EMIT_HIGH = 2'd2
    } emit_state_e;
endpackage

// File: rtl/crc16_byte_step.sv
// Combinational one-byte update of a reflected CRC-16 (generator 0xA001).
// Assumes least-significant-bit-first order. The eight serial shifts are
// collapsed: with d = data ^ crc_low and p its parity, the result is the old
// high byte moved low, XOR d placed at bits 6 and 7 of a 16-bit word, XOR
// 0xC001 when p is set.
module crc16_byte_step
    import crc16_guard_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [BYTE_W-1:0] mix;
    logic              par;
    logic [CRC_W-1:0]  wide;
    logic [CRC_W-1:0]  spread;
    logic [CRC_W-1:0]  par_term;

    // Purpose: closed-form byte update.
    always_comb begin
        mix      = data_i ^ crc_i[BYTE_W-1:0];
        par      = ^mix;
        wide     = {{(CRC_W-BYTE_W){1'b0}}, mix};
        spread   = (wide << 6) ^ (wide << 7);
        par_term = par ? 16'hC001 : '0;
        crc_o    = {{BYTE_W{1'b0}}, crc_i[CRC_W-1:BYTE_W]} ^ spread ^ par_term;
    end
endmodule

// File: rtl/crc16_accum.sv
// Running CRC register. Clearing takes priority over loading.
module crc16_accum
    import crc16_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CRC_W-1:0] next_i,
    output logic [CRC_W-1:0] crc_o
);
    // Purpose: hold, clear or advance the residue.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_o <= '0;
        else if (clear_i) crc_o <= '0;
        else if (load_i)  crc_o <= next_i;
    end
endmodule

// File: rtl/crc16_trailer_seq.sv
// Outputs the inverted register as two trailer bytes, low byte first.
// Assumes the register is frozen while busy_o is high.
module crc16_trailer_seq
    import crc16_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              trigger_i,
    input  logic [CRC_W-1:0]  crc_i,
    output logic              busy_o,
    output logic              trl_vld_o,
    output logic [BYTE_W-1:0] trl_byte_o
);
    emit_state_e state_q;

    // Purpose: step through the two trailer cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) state_q <= EMIT_IDLE;
        else begin
            case (state_q)
                EMIT_IDLE: if (trigger_i) state_q <= EMIT_LOW;
                EMIT_LOW:  state_q <= EMIT_HIGH;
                default:   state_q <= EMIT_IDLE;
            endcase
        end
    end

    // Purpose: select the inverted byte for the current trailer cycle.
    always_comb begin
        busy_o    = (state_q != EMIT_IDLE);
        trl_vld_o = busy_o;
        case (state_q)
            EMIT_LOW:  trl_byte_o = ~crc_i[BYTE_W-1:0];
            EMIT_HIGH: trl_byte_o = ~crc_i[CRC_W-1:BYTE_W];
            default:   trl_byte_o = '0;
        endcase
    end
endmodule

// File: rtl/crc16_verdict.sv
// Registers the pass or fail outcome of a read record; holds it otherwise.
module crc16_verdict
    import crc16_guard_pkg::*;
#(
    parameter logic [CRC_W-1:0] GOOD_RESIDUE = PASS_RESIDUE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             judge_i,
    input  logic [CRC_W-1:0] residue_i,
    output logic             pass_o,
    output logic             fail_o
);
    logic good;

    // Purpose: compare the final residue against the pass constant.
    always_comb good = (residue_i == GOOD_RESIDUE);

    // Purpose: update the verdict only when a read record is closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_o <= 1'b0;
            fail_o <= 1'b0;
        end else if (judge_i) begin
            pass_o <= good;
            fail_o <= !good;
        end
    end
endmodule

// File: rtl/crc16_record_guard.sv
// Top: byte-wide CRC-16 record guard. In write mode it produces an inverted
// two-byte trailer. In read mode it checks for the pass residue.
// Assumes one byte per cycle at most, and a start before each record.
module crc16_record_guard
    import crc16_guard_pkg::*;
#(
    parameter logic [CRC_W-1:0] GOOD_RESIDUE = PASS_RESIDUE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_vld_i,
    input  logic              eor_i,
    output logic [BYTE_W-1:0] trl_byte_o,
    output logic              trl_vld_o,
    output logic              pass_o,
    output logic              fail_o
);
    rec_mode_e        mode_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_step;
    logic [CRC_W-1:0] crc_after;
    logic             busy;
    logic             take_byte;
    logic             close_rec;

    // Purpose: latch the record mode when a record is opened.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_WRITE;
        else if (start_i) mode_q <= rec_mode_e'(mode_i);
    end

    // Purpose: decide what is accepted this cycle; start and output win.
    always_comb begin
        take_byte = byte_vld_i && !start_i && !busy;
        close_rec = eor_i && !start_i && !busy;
        crc_after = take_byte ? crc_step : crc_q;
    end

    crc16_byte_step u_step (
        .crc_i  (crc_q),
        .data_i (byte_i),
        .crc_o  (crc_step)
    );

    crc16_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .load_i  (take_byte),
        .next_i  (crc_step),
        .crc_o   (crc_q)
    );

    crc16_trailer_seq u_trl (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (start_i),
        .trigger_i  (close_rec && (mode_q == MODE_WRITE)),
        .crc_i      (crc_q),
        .busy_o     (busy),
        .trl_vld_o  (trl_vld_o),
        .trl_byte_o (trl_byte_o)
    );

    crc16_verdict #(.GOOD_RESIDUE(GOOD_RESIDUE)) u_ver (
        .clk       (clk),
        .rst_n     (rst_n),
        .judge_i   (close_rec && (mode_q == MODE_READ)),
        .residue_i (crc_after),
        .pass_o    (pass_o),
        .fail_o    (fail_o)
    );
endmodule

// File: rtl/crc16_guard_checker.sv
// Temporal checks for the CRC-16 record guard, bound to the top module.
module crc16_guard_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        eor_i,
    input logic        trl_vld_o,
    input logic        pass_o,
    input logic        fail_o,
    input logic [15:0] crc_q
);
    // R1: outputs quiet in the cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pass_o && !fail_o && !trl_vld_o));

    // R3: start clears the register and any trailer output
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (crc_q == 16'h0000 && !trl_vld_o));

    // R4: trailer output begins only after an end strobe
    p_trl_begin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trl_vld_o) |-> $past(eor_i));

    // R4: trailer output never lasts more than two cycles
    p_trl_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trl_vld_o) && $past(trl_vld_o, 2)) |-> !trl_vld_o);

    // R8: verdict moves only after an end strobe
    p_verdict_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eor_i) |-> ($stable(pass_o) && $stable(fail_o)));

    // R9: register frozen during trailer output
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trl_vld_o && !start_i) |=> $stable(crc_q));

    // R10: verdict outputs exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
endmodule

bind crc16_record_guard crc16_guard_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .eor_i     (eor_i),
    .trl_vld_o (trl_vld_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .crc_q     (crc_q)
);

// File: tb/sim_crc16_record_guard.sv
`timescale 1ns/1ps
module sim_crc16_record_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       byte_vld_i = 1'b0;
    logic       eor_i = 1'b0;
    logic [7:0] trl_byte_o;
    logic       trl_vld_o;
    logic       pass_o;
    logic       fail_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    crc16_record_guard u0 (.*);

    logic [7:0] rec [0:15];
    int         rec_n;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Bit-serial reference: reflected generator, LSB first.
    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_rec();
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < rec_n; i++) c = ref_step(c, rec[i]);
        return c;
    endfunction

    task automatic open_rec(input logic m);
        start_i = 1'b1; mode_i = m;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b, input logic last);
        byte_vld_i = 1'b1; byte_i = b; eor_i = last;
        @(negedge clk);
        byte_vld_i = 1'b0; eor_i = 1'b0;
    endtask

    task automatic close_only();
        eor_i = 1'b1;
        @(negedge clk);
        eor_i = 1'b0;
    endtask

    task automatic grab(output logic [15:0] t, output bit v_ok);
        v_ok = trl_vld_o;
        t[7:0] = trl_byte_o;
        @(negedge clk);
        v_ok = v_ok && trl_vld_o;
        t[15:8] = trl_byte_o;
        @(negedge clk);
        v_ok = v_ok && !trl_vld_o;
    endtask

    task automatic write_rec(output logic [15:0] t, output bit v_ok);
        open_rec(1'b0);
        for (int i = 0; i < rec_n; i++) feed(rec[i], i == rec_n - 1);
        grab(t, v_ok);
    endtask

    task automatic read_rec();
        open_rec(1'b1);
        for (int i = 0; i < rec_n; i++) feed(rec[i], i == rec_n - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [15:0] t, t2, c;
        bit v;
        logic [7:0] px, py;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!pass_o && !fail_o && !trl_vld_o, "R1 during reset", {pass_o, fail_o, trl_vld_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pass_o && !fail_o && !trl_vld_o, "R1 after reset", {pass_o, fail_o, trl_vld_o}, 0);

        // R2: reach 0x90F1 with two bytes, then fold 0x75 -> 0x6390
        px = 0; py = 0;
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                if (ref_step(ref_step(16'h0, 8'(x)), 8'(y)) == 16'h90F1) begin
                    px = 8'(x); py = 8'(y);
                end
        rec[0] = px; rec[1] = py; rec[2] = 8'h75; rec_n = 3;
        write_rec(t, v);
        check(t == ~16'h6390, "R2 vector 90F1+75", t, ~16'h6390);
        check(v, "R4 trailer valid for two cycles", v, 1);

        // R2 R4 R6 R5: sweep over every last byte, write then read back
        for (int b = 0; b < 256; b++) begin
            rec[0] = 8'(b * 7 + 3); rec[1] = 8'(b) ^ 8'h5A; rec[2] = 8'(b); rec_n = 3;
            c = ref_rec();
            write_rec(t, v);
            check(t == ~c && v, "R2 R4 R5 trailer sweep", t, ~c);
            rec[3] = t[7:0]; rec[4] = t[15:8]; rec_n = 5;
            read_rec();
            check(pass_o && !fail_o, "R6 R10 good record passes", {pass_o, fail_o}, 2'b10);
        end

        // R5: end strobe one cycle after the last byte gives the same trailer
        rec[0] = 8'h11; rec[1] = 8'h22; rec[2] = 8'h33; rec_n = 3;
        c = ref_rec();
        open_rec(1'b0);
        for (int i = 0; i < 3; i++) feed(rec[i], 1'b0);
        close_only();
        grab(t2, v);
        check(t2 == ~c && v, "R5 separate end strobe", t2, ~c);

        // R8: a write-mode end strobe leaves the pass verdict
        check(pass_o && !fail_o, "R8 verdict held over write record", {pass_o, fail_o}, 2'b10);

        // R7: all-zero read (shorted reader) fails
        for (int i = 0; i < 6; i++) rec[i] = 8'h00;
        rec_n = 6;
        read_rec();
        check(!pass_o && fail_o, "R7 all-zero record fails", {pass_o, fail_o}, 2'b01);

        // R8: opening a record does not touch the verdict
        open_rec(1'b1);
        check(!pass_o && fail_o, "R8 verdict held over start", {pass_o, fail_o}, 2'b01);

        // R7: plain register value as trailer fails
        rec[0] = 8'h01; rec[1] = 8'h02; rec[2] = 8'h03; rec_n = 3;
        c = ref_rec();
        rec[3] = c[7:0]; rec[4] = c[15:8]; rec_n = 5;
        read_rec();
        check(!pass_o && fail_o, "R7 plain trailer fails", {pass_o, fail_o}, 2'b01);

        // R6: long record passes, then a single flipped bit fails
        for (int i = 0; i < 14; i++) rec[i] = 8'(i * 37 + 5);
        rec_n = 14;
        c = ref_rec();
        rec[14] = ~c[7:0]; rec[15] = ~c[15:8]; rec_n = 16;
        read_rec();
        check(pass_o && !fail_o, "R6 long record passes", {pass_o, fail_o}, 2'b10);
        rec[6] = rec[6] ^ 8'h10;
        read_rec();
        check(!pass_o && fail_o, "R6 corrupted record fails", {pass_o, fail_o}, 2'b01);

        // R3: a byte arriving with start is discarded
        rec[0] = 8'hA5; rec[1] = 8'h3C; rec_n = 2;
        c = ref_rec();
        start_i = 1'b1; mode_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'hEE;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        feed(rec[0], 1'b0);
        feed(rec[1], 1'b1);
        grab(t, v);
        check(t == ~c && v, "R3 byte with start discarded", t, ~c);

        // R9: bytes and end strobes during trailer output are ignored
        rec[0] = 8'h5E; rec[1] = 8'h77; rec[2] = 8'h81; rec_n = 3;
        c = ref_rec();
        open_rec(1'b0);
        for (int i = 0; i < 3; i++) feed(rec[i], i == 2);
        t[7:0] = trl_byte_o;
        byte_vld_i = 1'b1; byte_i = 8'h5C; eor_i = 1'b1;
        @(negedge clk);
        t[15:8] = trl_byte_o;
        @(negedge clk);
        byte_vld_i = 1'b0; eor_i = 1'b0;
        check(t == ~c, "R9 trailer unaffected by input", t, ~c);
        check(!trl_vld_o, "R9 end strobe during output ignored", trl_vld_o, 0);
        close_only();
        grab(t2, v);
        check(t2 == ~c && v, "R9 register unaffected", t2, ~c);

        done = 1;
        report();
    end
endmodule